// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block drives one pulse-width-modulated output from an 8-bit period timer. Below the timer sits a 2-bit sub-cycle count, so the comparison time base is 10 bits wide. A selectable input prescaler (divide by 1, 4 or 16) sets how many input clocks make up one step of the time base. Software programs an 8-bit period value and a 10-bit duty value through a small register port. The duty value is split across a high byte and a 2-bit low field.

The duty fields are double-buffered. Software may rewrite them at any moment. The active duty register, which the output comparator uses, loads from the buffer only at a period boundary, so a running waveform never shows a half-updated duty. At each boundary the time base returns to zero and the output goes high, unless the newly loaded duty is zero. The output falls when the time base reaches the active duty. If the duty never fits inside the period, the output stays high for the whole period. Clearing the enable bit forces the output low and holds the time base at zero. The next enable starts a fresh period.

Top module: `pwm10_db`

## Requirements
- R1: After synchronous reset the output is low, every register reads zero, and the prescale is divide by 1.
- R2: With the prescale factor ps, one PWM period lasts (period+1)·4·ps input clocks, and the output rises once per period when 0 < duty < 4·(period+1).
- R3: Prescale code 0 selects divide by 1, code 1 selects divide by 4, and codes 2 and 3 both select divide by 16.
- R4: The duty value is {duty_hi, duty_lo}, and the output stays high for exactly duty·ps input clocks after each period start.
- R5: A duty written during a period has no effect on the output or on the active duty read-back until the next period boundary, where it is loaded.
- R6: When the duty loaded at a boundary is zero, the output stays low for that whole period.
- R7: When the active duty is at least 4·(period+1), the output stays high for the whole period.
- R8: While the enable bit is clear, the output is low one clock later and the time base is held at zero. Setting the enable bit starts a new period on the following clock and loads the buffered duty at that point.
- R9: Register map at reg_addr: 0 = period (8 bits), 1 = duty_hi (8 bits), 2 = control {bit 4 enable, bits 3:2 prescale code, bits 1:0 duty_lo}, 3 = active duty (10 bits, read-only, writes ignored). Reads are combinational and zero-extended to 10 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 10 | Read data for the selected register |
| pwm_out | output | 1 | PWM output |

## Verification
A behavioural model in the bench counts input clocks since the last period boundary and predicts the output and the read-back every clock. The duty patterns are chosen to separate distinct cases: a mid-range duty shows the rising and falling edges, zero separates the suppressed set from a short pulse, and a duty equal to or above the period length shows whether the clear is wrongly taken. Each prescale code is run with the same duty so that scaling errors show up as wrong pulse and period lengths. A duty rewritten in the middle of a period, together with an enable dropped while the output is high, tests that the buffer loads only at a boundary and that the output is forced low.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    localparam int TMR_W  = 8;
    localparam int SUB_W  = 2;
    localparam int TB_W   = TMR_W + SUB_W;
    localparam int PRE_W  = 4;
    localparam int ADDR_W = 2;
    localparam int WD_W   = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_PERIOD   = 2'd0,
        REG_DUTY_HI  = 2'd1,
        REG_CTRL     = 2'd2,
        REG_DUTY_ACT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV4   = 2'd1,
        PS_DIV16A = 2'd2,
        PS_DIV16B = 2'd3
    } presc_e;

    typedef struct packed {
        logic             enable;
        presc_e           presc;
        logic [SUB_W-1:0] duty_lo;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Last prescaler count before a time-base step.
    function automatic logic [PRE_W-1:0] presc_last(presc_e sel);
        case (sel)
            PS_DIV1: return PRE_W'(0);
            PS_DIV4: return PRE_W'(3);
            default: return PRE_W'(15);
        endcase
    endfunction

endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
    import pwm10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WD_W-1:0]   wdata,
    input  logic [TB_W-1:0]   act_duty,
    output logic [TMR_W-1:0]  period,
    output logic [TB_W-1:0]   duty_buf,
    output ctrl_t             ctrl,
    output logic [TB_W-1:0]   rdata
);

    logic [TMR_W-1:0] period_q;
    logic [TMR_W-1:0] duty_hi_q;
    ctrl_t            ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q  <= '0;
            duty_hi_q <= '0;
            ctrl_q    <= '0;
        end else if (we) begin
            case (reg_sel_e'(addr))
                REG_PERIOD:  period_q  <= wdata[TMR_W-1:0];
                REG_DUTY_HI: duty_hi_q <= wdata[TMR_W-1:0];
                REG_CTRL:    ctrl_q    <= ctrl_t'(wdata[CTRL_W-1:0]);
                default:     ;
            endcase
        end
    end

    assign period   = period_q;
    assign duty_buf = {duty_hi_q, ctrl_q.duty_lo};
    assign ctrl     = ctrl_q;

    always_comb begin
        case (reg_sel_e'(addr))
            REG_PERIOD:  rdata = TB_W'(period_q);
            REG_DUTY_HI: rdata = TB_W'(duty_hi_q);
            REG_CTRL:    rdata = TB_W'(ctrl_q);
            default:     rdata = act_duty;
        endcase
    end

    AST_PERIOD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_PERIOD) |=> period == $past(wdata[TMR_W-1:0])); // R9

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
    import pwm10_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [TMR_W-1:0] period,
    input  presc_e           presc,
    output logic             wrap,
    output logic             step,
    output logic [TB_W-1:0]  tb,
    output logic [TB_W-1:0]  tb_next
);

    logic [PRE_W-1:0] pre_q;
    logic [TMR_W-1:0] tmr_q;
    logic [SUB_W-1:0] sub_q;
    logic             run_q;
    logic             pre_done;
    logic             last_step;

    assign pre_done  = (pre_q >= presc_last(presc));
    assign last_step = pre_done && (sub_q == '1) && (tmr_q >= period);
    assign wrap      = en && (!run_q || last_step);
    assign step      = en && run_q && pre_done;
    assign tb        = {tmr_q, sub_q};
    assign tb_next   = tb + TB_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pre_q <= '0;
            tmr_q <= '0;
            sub_q <= '0;
            run_q <= 1'b0;
        end else if (wrap) begin
            pre_q <= '0;
            tmr_q <= '0;
            sub_q <= '0;
            run_q <= 1'b1;
        end else if (pre_done) begin
            pre_q <= '0;
            {tmr_q, sub_q} <= tb_next;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    AST_TB_ZERO_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
        wrap |=> tb == '0); // R2

    AST_TB_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> tb == '0); // R8

endmodule

// File: rtl/pwm10_outstage.sv
module pwm10_outstage
    import pwm10_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            wrap,
    input  logic            step,
    input  logic [TB_W-1:0] tb_next,
    input  logic [TB_W-1:0] duty_buf,
    output logic [TB_W-1:0] act_duty,
    output logic            pwm
);

    logic [TB_W-1:0] act_q;
    logic            out_q;
    logic            duty_hit;

    assign duty_hit = step && (tb_next == act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            out_q <= 1'b0;
        end else if (!en) begin
            out_q <= 1'b0;
        end else if (wrap) begin
            act_q <= duty_buf;
            out_q <= (duty_buf != '0);
        end else if (duty_hit) begin
            out_q <= 1'b0;
        end
    end

    assign act_duty = act_q;
    assign pwm      = out_q;

    AST_ACT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act_duty)); // R5

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
        (wrap && duty_buf == '0) |=> !pwm); // R6

    AST_SET_AT_START: assert property (@(posedge clk) disable iff (rst)
        (wrap && duty_buf != '0) |=> pwm); // R4

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm); // R8

endmodule

// File: rtl/pwm10_db.sv
module pwm10_db
    import pwm10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WD_W-1:0]   reg_wdata,
    output logic [TB_W-1:0]   reg_rdata,
    output logic              pwm_out
);

    logic [TMR_W-1:0] period;
    logic [TB_W-1:0]  duty_buf;
    logic [TB_W-1:0]  act_duty;
    ctrl_t            ctrl;
    logic             wrap;
    logic             step;
    logic [TB_W-1:0]  tb;
    logic [TB_W-1:0]  tb_next;

    pwm10_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .act_duty (act_duty),
        .period   (period),
        .duty_buf (duty_buf),
        .ctrl     (ctrl),
        .rdata    (reg_rdata)
    );

    pwm10_timebase u_tb (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.enable),
        .period  (period),
        .presc   (ctrl.presc),
        .wrap    (wrap),
        .step    (step),
        .tb      (tb),
        .tb_next (tb_next)
    );

    pwm10_outstage u_out (
        .clk      (clk),
        .rst      (rst),
        .en       (ctrl.enable),
        .wrap     (wrap),
        .step     (step),
        .tb_next  (tb_next),
        .duty_buf (duty_buf),
        .act_duty (act_duty),
        .pwm      (pwm_out)
    );

    AST_LOW_AT_TB_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wrap && act_duty == '0 && duty_buf == '0) |=> (tb == '0 && !pwm_out)); // R6

endmodule

// File: tb/pwm10_db_test.sv
`timescale 1ns/1ps
module pwm10_db_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [9:0] reg_rdata;
    logic       pwm_out;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    pwm10_db uut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    // Behavioural reference: clocks since the last period start.
    int m_pr = 0, m_hi = 0, m_ctrl = 0, m_act = 0, m_cnt = 0;
    bit m_run = 0, m_out = 0;

    function automatic int ps_of(int c);
        int code = (c >> 2) & 3;
        return (code == 0) ? 1 : (code == 1) ? 4 : 16;
    endfunction

    function automatic int buf_duty();
        return (m_hi << 2) | (m_ctrl & 3);
    endfunction

    function automatic int exp_rd(int a);
        case (a)
            0: return m_pr;
            1: return m_hi;
            2: return m_ctrl;
            default: return m_act;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pr = 0; m_hi = 0; m_ctrl = 0; m_act = 0;
            m_cnt = 0; m_run = 0; m_out = 0;
        end else begin
            if (((m_ctrl >> 4) & 1) == 0) begin
                m_run = 0; m_cnt = 0; m_out = 0;
            end else if (!m_run) begin
                m_run = 1; m_cnt = 0;
                m_act = buf_duty(); m_out = (m_act != 0);
            end else begin
                m_cnt++;
                if (m_cnt >= (m_pr + 1) * 4 * ps_of(m_ctrl)) begin
                    m_cnt = 0; m_act = buf_duty(); m_out = (m_act != 0);
                end else if (m_cnt == m_act * ps_of(m_ctrl)) begin
                    m_out = 0;
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_pr = reg_wdata;
                    2'd1: m_hi = reg_wdata;
                    2'd2: m_ctrl = reg_wdata & 8'h1F;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst) begin
            chk(cur_req, pwm_out, m_out, "pwm_out vs model");
            chk(cur_req, reg_rdata, exp_rd(reg_addr), "reg_rdata vs model");
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a[1:0]; reg_wdata = d[7:0];
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, int exp);
        @(posedge clk); #1;
        reg_addr = a[1:0];
        @(negedge clk);
        chk(req, reg_rdata, exp, "register read");
    endtask

    // Call right after enabling: waits for the start edge, then samples n clocks.
    task automatic meas(int n, output int hi, output int rises);
        bit prev = 0;
        hi = 0; rises = 0;
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hi, rs;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        cur_req = "R1";
        @(negedge clk);
        chk("R1", pwm_out, 0, "output after reset");
        for (int a = 0; a < 4; a++) rd_chk("R1", a, 0);

        cur_req = "R9";
        wr(0, 3); wr(1, 2); wr(2, 8'h01);
        rd_chk("R9", 0, 3);
        rd_chk("R9", 1, 2);
        rd_chk("R9", 2, 1);
        wr(3, 8'hFF);
        rd_chk("R9", 3, 0);

        cur_req = "R4";
        wr(2, 8'h11);
        meas(32, hi, rs);
        chk("R4", hi, 18, "high clocks duty 9 ps1 two periods");
        chk("R2", rs, 2, "rising edges in two periods of 16");

        cur_req = "R5";
        wr(1, 3);
        rd_chk("R5", 3, 9);
        repeat (16) @(posedge clk);
        rd_chk("R5", 3, 13);

        cur_req = "R8";
        wr(1, 2);
        wr(2, 8'h01);
        @(posedge clk);
        @(negedge clk);
        chk("R8", pwm_out, 0, "output after disable");

        cur_req = "R3";
        wr(2, 8'h15);
        meas(128, hi, rs);
        chk("R3", hi, 72, "high clocks ps code 1");
        chk("R3", rs, 2, "rising edges ps code 1");
        wr(2, 8'h01);
        wr(2, 8'h19);
        meas(512, hi, rs);
        chk("R3", hi, 288, "high clocks ps code 2");
        chk("R3", rs, 2, "rising edges ps code 2");
        wr(2, 8'h01);
        wr(2, 8'h1D);
        meas(512, hi, rs);
        chk("R3", hi, 288, "high clocks ps code 3");

        cur_req = "R2";
        wr(2, 8'h01);
        wr(0, 0); wr(1, 0);
        wr(2, 8'h12);
        meas(8, hi, rs);
        chk("R2", hi, 4, "high clocks period 0 duty 2");
        chk("R2", rs, 2, "rising edges period of 4");

        cur_req = "R6";
        wr(2, 8'h00);
        wr(0, 3);
        wr(2, 8'h10);
        meas(32, hi, rs);
        chk("R6", hi, 0, "high clocks with zero duty");

        cur_req = "R7";
        wr(2, 8'h00);
        wr(1, 4);
        wr(2, 8'h10);
        meas(32, hi, rs);
        chk("R7", hi, 32, "high clocks duty equal to period");
        chk("R7", rs, 1, "single rise with full duty");
        wr(2, 8'h00);
        wr(1, 8'hFF);
        wr(2, 8'h13);
        meas(32, hi, rs);
        chk("R7", hi, 32, "high clocks duty 1023");

        cur_req = "R8";
        wr(2, 8'h00);
        wr(1, 2);
        wr(2, 8'h11);
        repeat (3) @(posedge clk);
        #1;
        chk("R8", pwm_out, 1, "output high before disable");
        wr(2, 8'h01);
        @(posedge clk);
        @(negedge clk);
        chk("R8", pwm_out, 0, "output forced low mid-period");
        repeat (10) @(negedge clk) chk("R8", pwm_out, 0, "output held low while disabled");
        wr(2, 8'h11);
        meas(16, hi, rs);
        chk("R8", hi, 9, "fresh period after re-enable");
        chk("R8", rs, 1, "one rise after re-enable");

        repeat (4) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule